// File: doc/BRIEF.md
# 16-bit Compare/Capture Timer with Glitch-Free PWM

This block is a 16-bit up-counter with two compare channels, one capture channel and a single output pin. Software controls it over a byte-wide register bus. It has three modes. In free mode the counter only wraps around. In PWM mode compare 1 sets where the output edge falls inside the period and compare 2 ends the period. In one-pulse mode an edge on the capture pin starts a single pulse, and compare 1 ends that pulse.

Every restart loads the counter with 0xFFFC, not zero. The counter therefore runs through four extra states before it reaches 0x0000. A PWM period and a one-pulse width are each five cycles longer than the compare value that ends them.

In PWM mode, compare writes go to a shadow copy. The shadow copy moves into the active copy only on the compare-2 match that closes the period, so a period never runs with half-old and half-new limits. The bus is a plain register port and has no back-pressure: a write takes effect at the clock edge where it is presented. `bus_rdata_o` is combinational and is valid in the same cycle as `bus_rd_i`.

Top module: `tmr16_timer`

## Requirements
- R1: After reset all registers read zero except the counter, which reads 0xFFFC. `cmp_pin_o` is high and `irq_o` is low. The control register sits at address 0 and holds these fields:
  - bits[1:0]: mode, where 0 = free, 1 = PWM, 2 = one-pulse and 3 = free.
  - bit2: capture edge, 1 = rising, 0 = falling.
  - bit3: active output level.
  - bit4: capture interrupt enable.
  - bit5: compare interrupt enable.
  - bit6: run.
- R2: The counter counts up by one each clock while run is set and holds while run is clear. A read of address 2 returns the counter's upper byte and freezes the lower byte of that same cycle. A later read of address 3 returns that frozen byte, so the two reads together form one coherent 16-bit value.
- R3: Each compare register has two addresses: compare 1 uses 4 (high) and 5 (low), compare 2 uses 6 (high) and 7 (low). A high-byte write alone changes nothing that can be read back. The low-byte write completes the value, and outside PWM mode the value takes effect at once. Reads of these addresses return the active value.
- R4: In PWM mode a compare-2 match reloads the counter to 0xFFFC and drives the output to the active level. A compare-1 match drives the output to the opposite level. The active time is compare1+5 cycles and the period is compare2+5 cycles.
- R5: In PWM mode, values completed by a low-byte write stay invisible to read-back and to the output until the next compare-2 match. The following period then uses them.
- R6: The capture pin passes through a two-stage synchronizer. On the selected edge, the capture register (address 8 high, address 9 low) loads the counter value and status bit0 (address 1) is set.
- R7: In one-pulse mode a capture event restarts the counter at 0xFFFC and drives the output to the active level. A later compare-1 match returns the output to the inactive level, which gives a pulse of compare1+5 cycles.
- R8: While a one-pulse is active, further capture edges do not change the capture register or the pulse. Once the pulse ends, capture edges are accepted again.
- R9: A compare-1 match sets status bit1. Writing a 1 to a status bit clears it. `irq_o` is high exactly when a set status bit has its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 4 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid while bus_rd_i is high |
| cap_pin_i | input | 1 | Asynchronous capture input |
| cmp_pin_o | output | 1 | Compare / PWM / pulse output |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong active compare value or a stuck pending flag shows up in two places. Compare read-back returns a different value within one bus cycle. The duty cycle or period of the output pin changes within one PWM period. A wrong reload value or a lost pulse-busy state changes the measured pulse or period length by a fixed count, or extends it by a full counter wrap. Either shows up within the first pulse after the fault. A counter latch that tracks the live count shows up as a gap between two 16-bit reads that does not match the cycles between them.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int TMR_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    MODE_FREE  = 2'd0,
    MODE_PWM   = 2'd1,
    MODE_PULSE = 2'd2,
    MODE_ALT   = 2'd3
  } tmr_mode_e;

  // packed: run is bit6, mode occupies bits[1:0]
  typedef struct packed {
    logic      run;
    logic      cmp_ie;
    logic      cap_ie;
    logic      act_lvl;
    logic      cap_rise;
    tmr_mode_e mode;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);
  localparam int NCMP   = 2;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_STAT   = 4'd1;
  localparam logic [ADDR_W-1:0] A_CNT_H  = 4'd2;
  localparam logic [ADDR_W-1:0] A_CNT_L  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CMP1_H = 4'd4;
  localparam logic [ADDR_W-1:0] A_CMP1_L = 4'd5;
  localparam logic [ADDR_W-1:0] A_CMP2_H = 4'd6;
  localparam logic [ADDR_W-1:0] A_CMP2_L = 4'd7;
  localparam logic [ADDR_W-1:0] A_CAP_H  = 4'd8;
  localparam logic [ADDR_W-1:0] A_CAP_L  = 4'd9;
endpackage

// File: rtl/tmr16_edge.sv
module tmr16_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic rise_sel_i,
  output logic evt_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   settled;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin_i;
      end
    end
  endgenerate

  assign settled = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= settled;
  end

  assign evt_o = rise_sel_i ? (settled & ~prev_q) : (~settled & prev_q);
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int               CW     = 16,
  parameter logic [CW-1:0]    RELOAD = {{(CW-2){1'b1}}, 2'b00}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  tmr_mode_e     mode_i,
  input  logic          act_lvl_i,
  input  logic [CW-1:0] cmp1_i,
  input  logic [CW-1:0] cmp2_i,
  input  logic          cap_evt_i,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cap_o,
  output logic          out_o,
  output logic          busy_o,
  output logic          cmp1_hit_o,
  output logic          cap_take_o,
  output logic          period_end_o
);
  logic [CW-1:0] cnt_q, cap_q;
  logic          out_q, busy_q;
  logic          is_pwm, is_pulse, hit1, hit2, take, restart;

  assign is_pwm   = (mode_i == MODE_PWM);
  assign is_pulse = (mode_i == MODE_PULSE);
  assign hit1     = run_i && (cnt_q == cmp1_i);
  assign hit2     = run_i && (cnt_q == cmp2_i);
  assign take     = cap_evt_i && !(is_pulse && busy_q);
  assign restart  = (is_pwm && hit2) || (is_pulse && take);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= RELOAD;
      cap_q <= '0;
    end else begin
      if (restart)    cnt_q <= RELOAD;
      else if (run_i) cnt_q <= cnt_q + 1'b1;
      if (take)       cap_q <= cnt_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      case (mode_i)
        MODE_PWM: begin
          busy_q <= 1'b0;
          if (hit2)      out_q <= act_lvl_i;
          else if (hit1) out_q <= ~act_lvl_i;
        end
        MODE_PULSE: begin
          if (take) begin
            out_q  <= act_lvl_i;
            busy_q <= 1'b1;
          end else if (busy_q && hit1) begin
            out_q  <= ~act_lvl_i;
            busy_q <= 1'b0;
          end else if (!busy_q) begin
            out_q  <= ~act_lvl_i;
          end
        end
        default: begin
          out_q  <= ~act_lvl_i;
          busy_q <= 1'b0;
        end
      endcase
    end
  end

  assign cnt_o        = cnt_q;
  assign cap_o        = cap_q;
  assign out_o        = out_q;
  assign busy_o       = busy_q;
  assign cmp1_hit_o   = hit1;
  assign cap_take_o   = take;
  assign period_end_o = is_pwm && hit2;
endmodule

// File: rtl/tmr16_regs.sv
module tmr16_regs
  import tmr16_pkg::*;
#(
  parameter int CW = 16,
  parameter int BW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [BW-1:0] wdata_i,
  output logic [BW-1:0] rdata_o,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] cap_i,
  input  logic          period_end_i,
  input  logic          cmp_hit_i,
  input  logic          cap_take_i,
  output tmr_ctrl_t     ctrl_o,
  output logic [CW-1:0] cmp1_o,
  output logic [CW-1:0] cmp2_o,
  output logic          cap_flag_o,
  output logic          cmp_flag_o,
  output logic [BW-1:0] cnt_lat_o
);
  tmr_ctrl_t              ctrl_q;
  logic                   cap_flag_q, cmp_flag_q;
  logic [BW-1:0]          lat_q;
  logic [NCMP-1:0][CW-1:0] cmp_act;
  logic                   wr_stat, in_pwm;

  assign in_pwm  = (ctrl_q.mode == MODE_PWM);
  assign wr_stat = wr_i && (addr_i == A_STAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (wr_i && addr_i == A_CTRL) begin
      ctrl_q <= tmr_ctrl_t'(wdata_i[CTRL_W-1:0]);
    end
  end

  // set has priority over a same-cycle write-one-to-clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_flag_q <= 1'b0;
      cmp_flag_q <= 1'b0;
    end else begin
      if (cap_take_i)                cap_flag_q <= 1'b1;
      else if (wr_stat && wdata_i[0]) cap_flag_q <= 1'b0;
      if (cmp_hit_i)                 cmp_flag_q <= 1'b1;
      else if (wr_stat && wdata_i[1]) cmp_flag_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         lat_q <= '0;
    else if (rd_i && addr_i == A_CNT_H) lat_q <= cnt_i[BW-1:0];
  end

  for (genvar ch = 0; ch < NCMP; ch++) begin : g_cmp
    localparam logic [AW-1:0] A_HI = AW'(A_CMP1_H + 2 * ch);
    localparam logic [AW-1:0] A_LO = AW'(A_CMP1_H + 2 * ch + 1);
    logic [CW-1:0] shadow_q, act_q;
    logic          pend_q;
    logic          wr_hi, wr_lo;

    assign wr_hi = wr_i && (addr_i == A_HI);
    assign wr_lo = wr_i && (addr_i == A_LO);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_q <= '0;
        act_q    <= '0;
        pend_q   <= 1'b0;
      end else begin
        if (period_end_i && pend_q) begin
          act_q  <= shadow_q;
          pend_q <= 1'b0;
        end
        if (wr_hi) shadow_q[CW-1:BW] <= wdata_i;
        if (wr_lo) begin
          shadow_q[BW-1:0] <= wdata_i;
          if (in_pwm) begin
            pend_q <= 1'b1;
          end else begin
            act_q  <= {shadow_q[CW-1:BW], wdata_i};
            pend_q <= 1'b0;
          end
        end
      end
    end

    assign cmp_act[ch] = act_q;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        A_CTRL:   rdata_o[CTRL_W-1:0] = ctrl_q;
        A_STAT:   rdata_o[1:0]        = {cmp_flag_q, cap_flag_q};
        A_CNT_H:  rdata_o = cnt_i[CW-1:BW];
        A_CNT_L:  rdata_o = lat_q;
        A_CMP1_H: rdata_o = cmp_act[0][CW-1:BW];
        A_CMP1_L: rdata_o = cmp_act[0][BW-1:0];
        A_CMP2_H: rdata_o = cmp_act[1][CW-1:BW];
        A_CMP2_L: rdata_o = cmp_act[1][BW-1:0];
        A_CAP_H:  rdata_o = cap_i[CW-1:BW];
        A_CAP_L:  rdata_o = cap_i[BW-1:0];
        default:  rdata_o = '0;
      endcase
    end
  end

  assign ctrl_o     = ctrl_q;
  assign cmp1_o     = cmp_act[0];
  assign cmp2_o     = cmp_act[1];
  assign cap_flag_o = cap_flag_q;
  assign cmp_flag_o = cmp_flag_q;
  assign cnt_lat_o  = lat_q;
endmodule

// File: rtl/tmr16_timer.sv
module tmr16_timer
  import tmr16_pkg::*;
#(
  parameter int                  CW          = TMR_W,
  parameter int                  BW          = BYTE_W,
  parameter int                  AW          = ADDR_W,
  parameter int                  SYNC_STAGES = 2,
  parameter logic [CW-1:0]       RELOAD      = {{(CW-2){1'b1}}, 2'b00}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [BW-1:0] bus_wdata_i,
  output logic [BW-1:0] bus_rdata_o,
  input  logic          cap_pin_i,
  output logic          cmp_pin_o,
  output logic          irq_o
);
  tmr_ctrl_t     ctrl_w;
  logic [CW-1:0] cnt_w, cap_w, cmp1_w, cmp2_w;
  logic          cap_evt_w, busy_w, cmp1_hit_w, cap_take_w, period_end_w;
  logic          cap_flag_w, cmp_flag_w;
  logic [BW-1:0] cnt_lat_w;

  tmr16_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_i      (cap_pin_i),
    .rise_sel_i (ctrl_w.cap_rise),
    .evt_o      (cap_evt_w)
  );

  tmr16_core #(.CW(CW), .RELOAD(RELOAD)) core_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (ctrl_w.run),
    .mode_i       (ctrl_w.mode),
    .act_lvl_i    (ctrl_w.act_lvl),
    .cmp1_i       (cmp1_w),
    .cmp2_i       (cmp2_w),
    .cap_evt_i    (cap_evt_w),
    .cnt_o        (cnt_w),
    .cap_o        (cap_w),
    .out_o        (cmp_pin_o),
    .busy_o       (busy_w),
    .cmp1_hit_o   (cmp1_hit_w),
    .cap_take_o   (cap_take_w),
    .period_end_o (period_end_w)
  );

  tmr16_regs #(.CW(CW), .BW(BW), .AW(AW)) regs_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_i         (bus_wr_i),
    .rd_i         (bus_rd_i),
    .addr_i       (bus_addr_i),
    .wdata_i      (bus_wdata_i),
    .rdata_o      (bus_rdata_o),
    .cnt_i        (cnt_w),
    .cap_i        (cap_w),
    .period_end_i (period_end_w),
    .cmp_hit_i    (cmp1_hit_w),
    .cap_take_i   (cap_take_w),
    .ctrl_o       (ctrl_w),
    .cmp1_o       (cmp1_w),
    .cmp2_o       (cmp2_w),
    .cap_flag_o   (cap_flag_w),
    .cmp_flag_o   (cmp_flag_w),
    .cnt_lat_o    (cnt_lat_w)
  );

  assign irq_o = (cap_flag_w & ctrl_w.cap_ie) | (cmp_flag_w & ctrl_w.cmp_ie);
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk
  import tmr16_pkg::*;
#(
  parameter int            CW     = 16,
  parameter int            BW     = 8,
  parameter int            AW     = 4,
  parameter logic [CW-1:0] RELOAD = {{(CW-2){1'b1}}, 2'b00}
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input tmr_mode_e     mode,
  input logic          act_lvl,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cmp1_act,
  input logic [CW-1:0] cmp2_act,
  input logic          cap_evt,
  input logic          busy,
  input logic [CW-1:0] cap_val,
  input logic          cmp_pin,
  input logic          irq,
  input logic          cap_flag,
  input logic          cmp_flag,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [BW-1:0] cnt_lat
);
  logic pwm_end, pulse_start;
  assign pwm_end     = (mode == MODE_PWM) && run && (cnt == cmp2_act);
  assign pulse_start = (mode == MODE_PULSE) && cap_evt && !busy;

  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pwm_end && !pulse_start) |=> (cnt == $past(cnt) + 1'b1))
    else $error("R2 counter did not step");

  a_r2_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !pulse_start) |=> $stable(cnt))
    else $error("R2 counter moved while stopped");

  a_r2_low_latch: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_CNT_H) |=> (cnt_lat == $past(cnt[BW-1:0])))
    else $error("R2 low byte not frozen");

  a_r4_pwm_reload: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_end |=> (cnt == RELOAD && cmp_pin == $past(act_lvl)))
    else $error("R4 period end wrong");

  a_r5_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_PWM) && !pwm_end) |=> ($stable(cmp1_act) && $stable(cmp2_act)))
    else $error("R5 active compare changed mid-period");

  a_r7_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_start |=> (cnt == RELOAD && busy && cmp_pin == $past(act_lvl)))
    else $error("R7 pulse start wrong");

  a_r8_ignore_cap: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == MODE_PULSE) && cap_evt && busy) |=> $stable(cap_val))
    else $error("R8 capture taken during pulse");

  a_r9_cmp_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == cmp1_act) |=> cmp_flag)
    else $error("R9 compare flag not set");

  a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (cap_flag || cmp_flag))
    else $error("R9 interrupt without flag");
endmodule

bind tmr16_timer tmr16_chk #(.CW(CW), .BW(BW), .AW(AW), .RELOAD(RELOAD)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .run      (ctrl_w.run),
  .mode     (ctrl_w.mode),
  .act_lvl  (ctrl_w.act_lvl),
  .cnt      (cnt_w),
  .cmp1_act (cmp1_w),
  .cmp2_act (cmp2_w),
  .cap_evt  (cap_evt_w),
  .busy     (busy_w),
  .cap_val  (cap_w),
  .cmp_pin  (cmp_pin_o),
  .irq      (irq_o),
  .cap_flag (cap_flag_w),
  .cmp_flag (cmp_flag_w),
  .bus_rd   (bus_rd_i),
  .bus_addr (bus_addr_i),
  .cnt_lat  (cnt_lat_w)
);

// File: tb/tmr16_timer_tb_top.sv
module tmr16_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cap_pin = 1'b0;
  logic       cmp_pin, irq;

  int checks = 0, errors = 0, cyc = 0, rd_cyc = 0;
  bit done = 1'b0;

  tmr16_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .cap_pin_i(cap_pin), .cmp_pin_o(cmp_pin), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata; rd_cyc = cyc;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic rd16(input logic [3:0] a_hi, output logic [15:0] v, output int c);
    logic [7:0] h, l;
    rd(a_hi, h); c = rd_cyc;
    rd(a_hi + 4'd1, l);
    v = {h, l};
  endtask

  task automatic pulse_pin(input int n);
    @(negedge clk); cap_pin = 1'b1;
    repeat (n) @(negedge clk);
    cap_pin = 1'b0;
  endtask

  task automatic measure(input logic lvl, input bit want_lo, output int hi, output int lo);
    int guard = 0;
    hi = 0; lo = 0;
    @(negedge clk);
    while (cmp_pin == lvl && guard < 3000) begin @(negedge clk); guard++; end
    while (cmp_pin != lvl && guard < 3000) begin @(negedge clk); guard++; end
    while (cmp_pin == lvl && guard < 3000) begin hi++; @(negedge clk); guard++; end
    if (want_lo)
      while (cmp_pin != lvl && guard < 3000) begin lo++; @(negedge clk); guard++; end
  endtask

  // one-pulse capture with the counter stopped parks it at 0xFFFC
  task automatic rewind();
    wr(4'd0, 8'h06);
    pulse_pin(2);
    repeat (6) @(negedge clk);
    wr(4'd0, 8'h00);
  endtask

  task automatic t_reset();
    logic [7:0] d; logic [15:0] v; int c;
    rd(4'd0, d);       check("R1 ctrl after reset", d, 8'h00);
    rd16(4'd2, v, c);  check("R1 counter after reset", v, 16'hFFFC);
    check("R1 output after reset", cmp_pin, 1);
    check("R1 irq after reset", irq, 0);
  endtask

  task automatic t_cmp_flag();
    logic [7:0] d;
    wr(4'd4, 8'h00); wr(4'd5, 8'h10);
    wr(4'd0, 8'h60);
    repeat (30) @(negedge clk);
    rd(4'd1, d);  check("R9 compare flag set", d, 8'h02);
    #1 check("R9 irq with compare enabled", irq, 1);
    wr(4'd1, 8'h02);
    check("R9 irq after W1C", irq, 0);
    wr(4'd0, 8'h00);
  endtask

  task automatic t_byte_order();
    logic [7:0] d;
    wr(4'd4, 8'h12);
    rd(4'd4, d); check("R3 high byte alone no effect", d, 8'h00);
    wr(4'd5, 8'h34);
    rd(4'd4, d); check("R3 high after low write", d, 8'h12);
    rd(4'd5, d); check("R3 low after low write", d, 8'h34);
  endtask

  task automatic t_coherent();
    logic [15:0] v1, v2; logic [7:0] h, l; int c1, c2;
    wr(4'd0, 8'h40);
    rd(4'd2, h); c1 = rd_cyc;
    repeat (300) @(negedge clk);
    rd(4'd3, l); v1 = {h, l};
    rd16(4'd2, v2, c2);
    check("R2 coherent 16-bit delta", 16'(v2 - v1), 16'(c2 - c1));
    wr(4'd0, 8'h00);
  endtask

  task automatic t_capture_rise();
    logic [15:0] x, y, cv; logic [7:0] d; int c;
    wr(4'd0, 8'h44);
    repeat (37) @(negedge clk);
    wr(4'd0, 8'h04);
    rd16(4'd2, x, c);
    wr(4'd1, 8'h03);
    pulse_pin(3);
    repeat (6) @(negedge clk);
    rd16(4'd8, cv, c); check("R6 capture loads counter", cv, x);
    rd(4'd1, d);       check("R6 capture flag", d & 8'h01, 8'h01);
    rd16(4'd2, y, c);  check("R2 counter holds when stopped", y, x);
  endtask

  task automatic t_capture_fall();
    logic [7:0] d;
    wr(4'd0, 8'h00);
    wr(4'd1, 8'h01);
    @(negedge clk); cap_pin = 1'b1;
    repeat (6) @(negedge clk);
    rd(4'd1, d); check("R6 rising edge ignored when falling selected", d & 8'h01, 0);
    @(negedge clk); cap_pin = 1'b0;
    repeat (6) @(negedge clk);
    rd(4'd1, d); check("R6 falling edge captured", d & 8'h01, 1);
  endtask

  task automatic t_pwm();
    int hi, lo; logic [7:0] d;
    rewind();
    wr(4'd4, 8'h00); wr(4'd5, 8'd5);
    wr(4'd6, 8'h00); wr(4'd7, 8'd20);
    wr(4'd0, 8'h49);
    measure(1'b1, 1'b1, hi, lo);
    check("R4 PWM active time", hi, 10);
    check("R4 PWM inactive time", lo, 15);
    wr(4'd4, 8'h00); wr(4'd5, 8'd12);
    wr(4'd6, 8'h00); wr(4'd7, 8'd30);
    rd(4'd5, d); check("R5 old compare until period end", d, 8'd5);
    measure(1'b1, 1'b1, hi, lo);
    check("R5 new active time next period", hi, 17);
    check("R5 new inactive time next period", lo, 18);
    rd(4'd7, d); check("R5 compare2 applied", d, 8'd30);
    wr(4'd0, 8'h00);
  endtask

  task automatic t_pulse();
    int hi, lo, guard; logic [15:0] v1, v2; int c; logic [7:0] d;
    wr(4'd1, 8'h03);
    wr(4'd4, 8'h00); wr(4'd5, 8'd60);
    wr(4'd0, 8'h4E);
    fork
      measure(1'b1, 1'b0, hi, lo);
      begin
        pulse_pin(2);
        guard = 0;
        while (cmp_pin != 1'b1 && guard < 50) begin @(negedge clk); guard++; end
        repeat (10) @(negedge clk);
        rd16(4'd8, v1, c);
        pulse_pin(2);
        repeat (10) @(negedge clk);
        rd16(4'd8, v2, c);
      end
    join
    check("R7 one-pulse width", hi, 65);
    check("R8 capture ignored during pulse", v2, v1);
    pulse_pin(2);
    guard = 0;
    while (cmp_pin != 1'b1 && guard < 20) begin @(negedge clk); guard++; end
    check("R8 capture accepted after pulse", cmp_pin, 1);
    rd(4'd1, d); check("R7 capture flag in pulse mode", d & 8'h01, 1);
    wr(4'd0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmp_flag();
    t_byte_order();
    t_coherent();
    t_capture_rise();
    t_capture_fall();
    t_pwm();
    t_pulse();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule